// File: doc/BRIEF.md
# Limit-Compare Timer with Free-Running User Mode

This block is a timer peripheral with a plain 32-bit register bus and one level-sensitive interrupt line. A clock divider makes a single-cycle tick every `TICK_DIV` core clocks. The divisor is chosen so that the tick period is 500 ns. Each tick advances the count by one step. The count is shown to software with its step at bit 9, so bits 8 to 0 of every count and limit value read as zero.

The block has two personalities. In system mode the count climbs to a programmable limit. On that tick the block raises a reached flag and the interrupt. On the following tick the count wraps to zero and keeps going. Software acknowledges the event by reading the limit word. In user mode the block is a 64-bit free-running counter that software starts and stops. It never interrupts.

A parameter decides whether the instance is local to one processor, and so may switch modes at run time. The alternative is a shared system timer, which stays in system mode for good.

Top module: `tick_limit_timer`

## Requirements
- R1: The count advances by exactly one step, worth 0x200 in the register view, on each tick. A tick occurs once every `TICK_DIV` clocks, counted from the release of reset. Bits 8..0 of any count or limit read are zero.
- R2: The word index is `bus_addr[4:2]`. Other address bits are ignored. Index 0 is the limit with restart, 1 the count, 2 the limit without restart, 3 run/stop and 4 the mode. Indices 5, 6 and 7 read as zero, and writes to them change nothing.
- R3: A write to index 0 or index 2 stores `wdata & 0x7FFFFE00` as the limit. If that masked value is zero, 0x7FFFFE00 is stored instead. A write to index 0 also restarts the count from zero and drops the interrupt, but leaves the reached flag as it is. A write to index 2 leaves the count running undisturbed.
- R4: In system mode, the tick that brings the count equal to the limit sets the reached flag and raises the interrupt. The next tick returns the count to zero. Counting then continues.
- R5: In system mode, a read of index 1 returns the reached flag in bit 31 and count bits 30..0 below it.
- R6: In system mode, a read of index 0 returns the limit and clears both the reached flag and the interrupt. If a reached event happens at the same edge as this read, the event wins and both stay set.
- R7: In user mode, index 0 reads bits 62..32 of the 64-bit count with bit 31 forced to zero. Index 1 reads count bits 31..0. The interrupt stays low throughout user mode.
- R8: A write to index 3 acts only in user mode: bit 0 = 1 stops the count and bit 0 = 0 runs it. A stopped count holds its value. System mode always counts, whatever the stopped status. Index 3 reads the stopped status in bit 0.
- R9: A write to index 4 sets the mode from bit 0 (1 = user, 0 = system), but only when `PER_CPU` is 1. A system instance keeps mode 0. Entering user mode drops the interrupt and sets the limit to 0x7FFFFE00. Every write to index 4 restarts the count from zero. Index 4 reads the mode in bit 0.
- R10: After reset the limit is 0x7FFFFE00, the count and the reached flag are zero, the interrupt is low, the stopped status is 1 and the mode is system.
- R11: Read data appears on `bus_rdata` one clock after the read strobe. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address; bits 4..2 select the word |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, system mode only |

## Verification
The hardest situation to create from the ports is an acknowledge read of the limit word that lands on the very edge where the count meets the limit. Only the event-wins rule separates a correct design from a faulty one at that point. The bench's reference model tracks both the divider phase and the count. Stimulus waits until the model predicts a reached event on the coming edge, and then issues the word-0 read for that edge. A second case that is easy to miss is a limit-with-restart write while the flag is set. That write must drop the interrupt but keep bit 31 of the count word. It is reached by letting an event fire, writing the limit, and reading the count word straight afterwards.

// File: rtl/tlt_pkg.sv
package tlt_pkg;
  // Register view: one count step sits at bit FRAC_W.
  localparam int FRAC_W = 9;
  localparam int LIM_W  = 31 - FRAC_W;   // limit field, in steps
  localparam int CNT_W  = 64 - FRAC_W;   // full count, in steps

  localparam logic [2:0] WD_LIM_RST  = 3'd0;
  localparam logic [2:0] WD_COUNT    = 3'd1;
  localparam logic [2:0] WD_LIM_KEEP = 3'd2;
  localparam logic [2:0] WD_RUNSTOP  = 3'd3;
  localparam logic [2:0] WD_MODE     = 3'd4;

  // Control events from the register side into the counting core.
  typedef struct packed {
    logic restart;   // count back to zero this edge
    logic irq_drop;  // lower interrupt this edge
    logic ack;       // system-mode read of the limit word
  } ctl_ev_t;
endpackage

// File: rtl/tlt_tick_gen.sv
module tlt_tick_gen #(
  parameter int TICK_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pc_q;

  assign tick = (pc_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (tick) pc_q <= '0;
    else           pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/tlt_ctrl.sv
module tlt_ctrl
  import tlt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PER_CPU = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [2:0]        word,
  output ctl_ev_t           ev,
  output logic [LIM_W-1:0]  limit_q,
  output logic              user_q,
  output logic              stop_q
);
  logic             wr_lim_any;
  logic             wr_lim_rst;
  logic             wr_mode;
  logic             enter_user;
  logic [LIM_W-1:0] lim_in;

  assign word       = bus_addr[4:2];
  assign wr_lim_rst = bus_wr && (word == WD_LIM_RST);
  assign wr_lim_any = wr_lim_rst || (bus_wr && (word == WD_LIM_KEEP));
  assign wr_mode    = bus_wr && (word == WD_MODE);
  assign lim_in     = bus_wdata[30:FRAC_W];

  generate
    if (PER_CPU != 0) begin : g_cpu
      assign enter_user = wr_mode && bus_wdata[0];
      always_ff @(posedge clk) begin
        if (rst)          user_q <= 1'b0;
        else if (wr_mode) user_q <= bus_wdata[0];
      end
    end else begin : g_sys
      assign enter_user = 1'b0;
      assign user_q     = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)             limit_q <= '1;
    else if (enter_user) limit_q <= '1;
    else if (wr_lim_any) limit_q <= (lim_in == '0) ? '1 : lim_in;
  end

  always_ff @(posedge clk) begin
    if (rst)
      stop_q <= 1'b1;
    else if (bus_wr && (word == WD_RUNSTOP) && user_q)
      stop_q <= bus_wdata[0];
  end

  always_comb begin
    ev.restart  = wr_lim_rst || wr_mode;
    ev.irq_drop = wr_lim_rst || enter_user;
    ev.ack      = bus_rd && (word == WD_LIM_RST) && !user_q;
  end

  logic unused_ctrl;
  assign unused_ctrl = ^{bus_addr[ADDR_W-1:5], bus_addr[1:0],
                         bus_wdata[31], bus_wdata[FRAC_W-1:1]};
endmodule

// File: rtl/tlt_count_core.sv
module tlt_count_core
  import tlt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             user_q,
  input  logic             stop_q,
  input  logic [LIM_W-1:0] limit_q,
  input  ctl_ev_t          ev,
  output logic [CNT_W-1:0] cnt_q,
  output logic             reached_q,
  output logic             irq_q
);
  logic [LIM_W-1:0] low;
  logic [LIM_W-1:0] inc;
  logic             at_lim;
  logic             hit;

  assign low    = cnt_q[LIM_W-1:0];
  assign inc    = low + 1'b1;
  assign at_lim = (low == limit_q);
  // Event on the tick that lands the count on the limit.
  assign hit    = tick && !user_q && !ev.restart && !at_lim && (inc == limit_q);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (ev.restart)
      cnt_q <= '0;
    else if (tick) begin
      if (user_q) begin
        if (!stop_q) cnt_q <= cnt_q + 1'b1;
      end else if (at_lim) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= CNT_W'(inc);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reached_q <= 1'b0;
    else if (hit)    reached_q <= 1'b1;
    else if (ev.ack) reached_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                         irq_q <= 1'b0;
    else if (hit)                    irq_q <= 1'b1;
    else if (ev.ack || ev.irq_drop)  irq_q <= 1'b0;
  end
endmodule

// File: rtl/tick_limit_timer.sv
module tick_limit_timer
  import tlt_pkg::*;
#(
  parameter int TICK_DIV = 50,
  parameter int PER_CPU  = 1,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic             tick;
  logic [2:0]       word;
  ctl_ev_t          ev;
  logic [LIM_W-1:0] limit_q;
  logic             user_q;
  logic             stop_q;
  logic [CNT_W-1:0] cnt_q;
  logic             reached_q;
  logic [63:0]      full;
  logic [31:0]      rd_next;

  tlt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  tlt_ctrl #(.ADDR_W(ADDR_W), .PER_CPU(PER_CPU)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .word     (word),
    .ev       (ev),
    .limit_q  (limit_q),
    .user_q   (user_q),
    .stop_q   (stop_q)
  );

  tlt_count_core u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .user_q   (user_q),
    .stop_q   (stop_q),
    .limit_q  (limit_q),
    .ev       (ev),
    .cnt_q    (cnt_q),
    .reached_q(reached_q),
    .irq_q    (irq)
  );

  assign full = {cnt_q, {FRAC_W{1'b0}}};

  always_comb begin
    unique case (word)
      WD_LIM_RST: rd_next = user_q ? {1'b0, full[62:32]}
                                   : {1'b0, limit_q, {FRAC_W{1'b0}}};
      WD_COUNT:   rd_next = user_q ? full[31:0] : {reached_q, full[30:0]};
      WD_RUNSTOP: rd_next = {31'b0, stop_q};
      WD_MODE:    rd_next = {31'b0, user_q};
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  logic unused_top;
  assign unused_top = full[63];
endmodule

// File: rtl/tlt_checker.sv
module tlt_checker
  import tlt_pkg::*;
#(
  parameter int PER_CPU = 1,
  parameter int ADDR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              tick,
  input logic              user_q,
  input logic              stop_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              reached_q,
  input logic              irq
);
  logic [2:0] w;
  assign w = bus_addr[4:2];

  // R1: tick is a single-cycle pulse
  a_r1_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R3: limit-with-restart write zeroes the count and lowers the interrupt
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && w == WD_LIM_RST) |=> (cnt_q == '0 && !irq));

  // R4, R6: interrupt is never high without the reached flag
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> reached_q);

  // R7: user mode never interrupts
  a_r7_user_quiet: assert property (@(posedge clk) disable iff (rst)
    user_q |-> !irq);

  // R8: a stopped user count holds unless restarted
  a_r8_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (user_q && stop_q && !(bus_wr && (w == WD_LIM_RST || w == WD_MODE)))
      |=> $stable(cnt_q));

  // R9: a system instance never leaves system mode
  a_r9_system_fixed: assert property (@(posedge clk) disable iff (rst)
    (PER_CPU == 0) |-> !user_q);

  // R11: read data holds when no read is strobed
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  logic unused_chk;
  assign unused_chk = ^{bus_addr[ADDR_W-1:5], bus_addr[1:0]};
endmodule

bind tick_limit_timer tlt_checker #(.PER_CPU(PER_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .tick     (tick),
  .user_q   (user_q),
  .stop_q   (stop_q),
  .cnt_q    (cnt_q),
  .reached_q(reached_q),
  .irq      (irq)
);

// File: tb/tick_limit_timer_bench.sv
module tick_limit_timer_bench;
  localparam int DIV = 4;
  localparam logic [63:0] LMASK = 64'h0000_0000_003F_FFFF;
  localparam logic [63:0] CMASK = 64'h007F_FFFF_FFFF_FFFF;
  localparam logic [31:0] DEF_LIM = 32'h7FFF_FE00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic        irq, irq_s;

  tick_limit_timer #(.TICK_DIV(DIV), .PER_CPU(1), .ADDR_W(8)) u_tick_limit_timer (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  tick_limit_timer #(.TICK_DIV(DIV), .PER_CPU(0), .ADDR_W(8)) u_sys (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata_s), .irq(irq_s)
  );

  always #4 clk = ~clk;

  // Reference model state
  logic [63:0] m_cnt;
  logic [31:0] m_lim;
  logic        m_reached, m_irq, m_user, m_stop, m_rdp;
  logic [31:0] m_rdv;
  int          m_pre, m_rdidx;
  int          b_idx;
  logic        b_tick, b_restart, b_enter, b_ack, b_hit;
  logic [63:0] b_full, b_low, b_limt;

  int    vectors = 0;
  int    miscompares = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R10";

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_lim = DEF_LIM; m_reached = 0; m_irq = 0;
      m_user = 0; m_stop = 1; m_pre = 0; m_rdv = '0; m_rdp = 0; m_rdidx = 0;
    end else begin
      b_idx     = int'(addr[4:2]);
      b_tick    = (m_pre == DIV - 1);
      m_pre     = b_tick ? 0 : m_pre + 1;
      b_full    = m_cnt << 9;
      b_limt    = {32'b0, m_lim} >> 9;
      b_low     = m_cnt & LMASK;
      b_restart = wr && (b_idx == 0 || b_idx == 4);
      b_enter   = wr && (b_idx == 4) && wdata[0];
      b_ack     = rd && (b_idx == 0) && !m_user;
      b_hit     = b_tick && !b_restart && !m_user && (b_low != b_limt)
                  && (((b_low + 64'd1) & LMASK) == b_limt);
      m_rdp = rd;
      if (rd) begin
        m_rdidx = b_idx;
        case (b_idx)
          0: m_rdv = m_user ? {1'b0, b_full[62:32]} : m_lim;
          1: m_rdv = m_user ? b_full[31:0] : {m_reached, b_full[30:0]};
          3: m_rdv = {31'b0, m_stop};
          4: m_rdv = {31'b0, m_user};
          default: m_rdv = '0;
        endcase
      end
      if (b_restart) m_cnt = '0;
      else if (b_tick) begin
        if (m_user) begin
          if (!m_stop) m_cnt = (m_cnt + 64'd1) & CMASK;
        end else if (b_low == b_limt) m_cnt = '0;
        else m_cnt = (b_low + 64'd1) & LMASK;
      end
      if (b_hit) m_reached = 1;
      else if (b_ack) m_reached = 0;
      if (b_hit) m_irq = 1;
      else if (b_ack || (wr && b_idx == 0) || b_enter) m_irq = 0;
      if (wr && b_idx == 3 && m_user) m_stop = wdata[0];
      if (b_enter) m_lim = DEF_LIM;
      else if (wr && (b_idx == 0 || b_idx == 2))
        m_lim = ((wdata & DEF_LIM) == 0) ? DEF_LIM : (wdata & DEF_LIM);
      if (wr && b_idx == 4) m_user = wdata[0];
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(m_rdp ? cur_req : "R11", "rdata", rdata, m_rdv);
      check(cur_req, "irq", {31'b0, irq}, {31'b0, m_irq});
      if (m_rdp && m_rdidx == 4) check("R9", "system instance mode", rdata_s, 32'h0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      miscompares++;
      $display("FAIL %s watchdog: actual=%0d expected=%0d", cur_req, cyc, 20000);
      finish_run();
    end
  end

  task automatic bread_a(logic [7:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bread(int w);
    bread_a(8'(w * 4));
  endtask

  task automatic bwrite(int w, logic [31:0] d);
    @(negedge clk); addr = 8'(w * 4); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Issue a limit-word read on the edge the model expects an event
  task automatic read_at_hit();
    @(negedge clk);
    while (!((m_pre == DIV - 1) && !m_user
             && ((m_cnt & LMASK) != ({32'b0, m_lim} >> 9))
             && ((((m_cnt & LMASK) + 64'd1) & LMASK) == ({32'b0, m_lim} >> 9))))
      @(negedge clk);
    addr = 8'h00; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  logic [31:0] held;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    cur_req = "R10";
    check("R10", "irq after reset", {31'b0, irq}, 32'h0);
    bread(0); check("R10", "limit after reset", rdata, DEF_LIM);
    bread(3); check("R10", "stopped after reset", rdata, 32'h1);
    bread(4); check("R10", "mode after reset", rdata, 32'h0);

    cur_req = "R1";
    for (int i = 0; i < 6; i++) begin
      bread(1);
      check("R1", "count low bits", rdata & 32'h1FF, 32'h0);
      idle(i);
    end

    cur_req = "R8";
    bwrite(3, 32'h0); bread(3); check("R8", "run ignored in system mode", rdata, 32'h1);

    cur_req = "R3";
    bwrite(0, 32'h0000_0600);
    bread(0); check("R3", "limit stored", rdata, 32'h0000_0600);

    cur_req = "R4";
    idle(40);
    cur_req = "R5";
    bread(1); check("R5", "reached bit", {31'b0, rdata[31]}, 32'h1);

    cur_req = "R6";
    bread(0); check("R6", "limit read", rdata, 32'h0000_0600);
    read_at_hit();
    check("R6", "event wins over ack", {31'b0, irq}, 32'h1);
    bread(1); check("R6", "flag kept after collision", {31'b0, rdata[31]}, 32'h1);

    cur_req = "R3";
    while (!irq) @(negedge clk);
    bwrite(0, 32'h0000_0600);
    check("R3", "irq dropped by limit write", {31'b0, irq}, 32'h0);
    bread(1); check("R3", "flag kept by limit write", {31'b0, rdata[31]}, 32'h1);
    bwrite(0, 32'h0000_1000); idle(14);
    bwrite(2, 32'h0000_2000); bread(1); idle(30);
    bwrite(2, 32'hFFFF_FFFF); bread(0); check("R3", "masked all-ones", rdata, DEF_LIM);
    bwrite(2, 32'h0000_01FF); bread(0); check("R3", "zero replaced", rdata, DEF_LIM);
    bwrite(2, 32'h8000_0A5F); bread(0); check("R3", "masked value", rdata, 32'h0000_0A00);

    cur_req = "R2";
    bread(5); check("R2", "index 5", rdata, 32'h0);
    bread(7); check("R2", "index 7", rdata, 32'h0);
    bwrite(6, 32'h0000_0400);
    bread(0); check("R2", "write to index 6 ignored", rdata, 32'h0000_0A00);
    bread_a(8'hF0); check("R2", "upper address bits ignored", rdata, 32'h0);

    cur_req = "R9";
    bwrite(4, 32'h1);
    check("R9", "irq low in user mode", {31'b0, irq}, 32'h0);
    bread(4); check("R9", "mode reads user", rdata, 32'h1);
    cur_req = "R8";
    idle(10);
    bread(1); check("R8", "stopped count holds zero", rdata, 32'h0);
    bwrite(3, 32'h0); idle(30);
    bread(1); bread(3); check("R8", "running status", rdata, 32'h0);
    bwrite(3, 32'h1); bread(1); held = rdata;
    idle(20);
    bread(1); check("R8", "stopped count held", rdata, held);
    bwrite(3, 32'h0);

    cur_req = "R7";
    bread(0); check("R7", "high word", rdata, 32'h0);
    idle(60);
    bwrite(0, 32'h0000_0600); idle(40);
    bread(1); bread(0);

    cur_req = "R9";
    bwrite(4, 32'h0);
    bread(0); check("R9", "limit after user write", rdata, 32'h0000_0600);
    while (!irq) @(negedge clk);
    bwrite(4, 32'h1);
    check("R9", "enter user drops irq", {31'b0, irq}, 32'h0);
    bwrite(4, 32'h0);
    bread(0); check("R9", "limit set by user entry", rdata, DEF_LIM);
    idle(8);

    finish_run();
  end
endmodule